// File: doc/BRIEF.md
# Serial Converter Interface Framing Engine

This block is the device-side serial front end of an 8-bit multi-channel successive-approximation converter. A host selects the device with an active-low select line, drives a serial clock, and sends control bytes on a data-in line. The block works entirely in a system clock domain. It synchronises the select, serial clock and data-in lines and detects the serial clock edges. It finds the start of each control byte, collects the byte, starts a conversion and returns the result bit-serially on data-out.

The analog core is not part of the block. The conversion value is taken from a parallel input at the moment the conversion starts. A control byte does not begin when select falls. It begins with the first high bit seen on data-in. Because of this rule, a host can stream frames of 10 or 16 serial clocks: the next control byte overlaps the tail of the previous result. Raising the select line abandons whatever capture or conversion is under way.

Top module: `sadc_frame`

## Requirements
- R1: After synchronous reset, `dout` is 0 and `ctrl_strobe` is 0.
- R2: A falling edge on `cs_n` does not by itself begin a frame. While `cs_n` is low, data-in bits sampled as 0 on rising `sclk` edges produce no `ctrl_strobe`, and `dout` stays 0.
- R3: Data-in is sampled on rising `sclk` edges. The first 1 accepted as a start bit becomes bit 7 of the control word. The next seven rising edges supply bits 6 down to 0, MSB first. `ctrl_word` then holds the byte, and `ctrl_strobe` is high for exactly one system clock.
- R4: On the falling `sclk` edge after the eighth control bit, `result_in` is latched and a one-SCLK busy slot begins, with `dout` at 0. The next falling edge drives result bit 7.
- R5: Result bits 7 down to 0 appear on `dout` on successive falling `sclk` edges. On the falling edge after bit 0, `dout` returns to 0.
- R6: A 1 on data-in is not accepted as a start bit while a control byte is being collected, or between its eighth bit and the falling edge that drives result bit 7 (this includes the busy slot).
- R7: After result bit 7 has been driven, a 1 on data-in is accepted as the next start bit while the remaining result bits are still shifting. This allows back-to-back frames of 9, 10 or 16 SCLKs.
- R8: While `cs_n` is high, `dout` is 0. A high `cs_n` discards a partly collected control byte, any pending conversion and any result being shifted. After `cs_n` falls again, the next 1 on data-in is a start bit.
- R9: `dout` changes only after a falling `sclk` edge or a high `cs_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low device select, asynchronous to clk |
| sclk | input | 1 | Serial clock from the host, asynchronous to clk |
| din | input | 1 | Serial control data from the host |
| result_in | input | 8 | Parallel conversion value from the analog core |
| dout | output | 1 | Serial result, MSB first |
| ctrl_word | output | 8 | Last captured control byte |
| ctrl_strobe | output | 1 | One-cycle pulse when ctrl_word is updated |

## Verification
The hardest situations to reach are a start bit placed on the very first rising edge after result bit 7 is driven, and a select toggle that lands midway through a result. The stimulus reaches the first case by streaming frames back to back: 9-SCLK and 10-SCLK frames, so that each new control byte overlaps the previous result. It reaches the second by raising select after four result bits and after half a control byte. A high bit placed in the busy slot shows that a start bit is refused there.

// File: rtl/sadc_pkg.sv
package sadc_pkg;
  localparam int CTRL_W = 8;
  localparam int DATA_W = 8;

  typedef enum logic [1:0] {
    SH_IDLE = 2'd0,
    SH_ACQ  = 2'd1,
    SH_OUT  = 2'd2
  } sh_state_t;
endpackage

// File: rtl/sadc_sync.sv
module sadc_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] INIT = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  genvar i;
  generate
    for (i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stg[i] <= INIT;
          else     stg[i] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stg[i] <= INIT;
          else     stg[i] <= stg[i-1];
        end
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/sadc_capture.sv
module sadc_capture #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          rise,
  input  logic          din,
  input  logic          arm,
  output logic [CW-1:0] word,
  output logic          done,
  output logic          active
);
  localparam int CNT_W = $clog2(CW);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CW - 2);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      word   <= '0;
      done   <= 1'b0;
      active <= 1'b0;
      cnt    <= '0;
    end else if (clr) begin
      done   <= 1'b0;
      active <= 1'b0;
      cnt    <= '0;
    end else begin
      done <= 1'b0;
      if (rise) begin
        if (active) begin
          word <= {word[CW-2:0], din};
          if (cnt == LAST) begin
            active <= 1'b0;
            done   <= 1'b1;
            cnt    <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end else if (arm && din) begin
          word   <= CW'(1);
          active <= 1'b1;
          cnt    <= '0;
        end
      end
    end
  end
endmodule

// File: rtl/sadc_shifter.sv
module sadc_shifter
  import sadc_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          fall,
  input  logic          start,
  input  logic [DW-1:0] result_in,
  output logic          dout,
  output sh_state_t     st
);
  localparam int IW = $clog2(DW);

  logic [DW-1:0] res;
  logic [IW-1:0] idx;
  logic [IW-1:0] idx_nxt;

  assign idx_nxt = idx - 1'b1;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      res  <= '0;
      idx  <= '0;
      dout <= 1'b0;
      st   <= SH_IDLE;
    end else if (fall) begin
      if (start) begin
        res  <= result_in;
        dout <= 1'b0;
        st   <= SH_ACQ;
      end else begin
        case (st)
          SH_ACQ: begin
            st   <= SH_OUT;
            idx  <= IW'(DW - 1);
            dout <= res[DW-1];
          end
          SH_OUT: begin
            if (idx == '0) begin
              st   <= SH_IDLE;
              dout <= 1'b0;
            end else begin
              idx  <= idx_nxt;
              dout <= res[idx_nxt];
            end
          end
          default: dout <= 1'b0;
        endcase
      end
    end
  end
endmodule

// File: rtl/sadc_frame.sv
module sadc_frame
  import sadc_pkg::*;
#(
  parameter int CW        = CTRL_W,
  parameter int DW        = DATA_W,
  parameter int SYNC_STGS = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cs_n,
  input  logic          sclk,
  input  logic          din,
  input  logic [DW-1:0] result_in,
  output logic          dout,
  output logic [CW-1:0] ctrl_word,
  output logic          ctrl_strobe
);
  logic [2:0] raw_in;
  logic [2:0] sync_q;
  logic       cs_hi;
  logic       sclk_s;
  logic       din_s;
  logic       sclk_q;
  logic       sclk_rise;
  logic       sclk_fall;
  logic       cap_active;
  logic       cap_done;
  logic       pend;
  logic       arm;
  sh_state_t  sh_st;

  assign raw_in = {cs_n, sclk, din};

  sadc_sync #(.W(3), .STAGES(SYNC_STGS), .INIT(3'b100)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (raw_in),
    .q   (sync_q)
  );

  assign cs_hi  = sync_q[2];
  assign sclk_s = sync_q[1];
  assign din_s  = sync_q[0];

  always_ff @(posedge clk) begin
    if (rst) sclk_q <= 1'b0;
    else     sclk_q <= sclk_s;
  end

  assign sclk_rise = sclk_s & ~sclk_q;
  assign sclk_fall = ~sclk_s & sclk_q;

  // start bits accepted only when no byte is open, none is waiting to
  // convert, and the busy slot is over (result MSB already driven)
  assign arm = !cap_active && !cap_done && !pend && (sh_st != SH_ACQ);

  sadc_capture #(.CW(CW)) u_cap (
    .clk    (clk),
    .rst    (rst),
    .clr    (cs_hi),
    .rise   (sclk_rise),
    .din    (din_s),
    .arm    (arm),
    .word   (ctrl_word),
    .done   (cap_done),
    .active (cap_active)
  );

  assign ctrl_strobe = cap_done;

  always_ff @(posedge clk) begin
    if (rst || cs_hi)   pend <= 1'b0;
    else if (cap_done)  pend <= 1'b1;
    else if (sclk_fall) pend <= 1'b0;
  end

  sadc_shifter #(.DW(DW)) u_shf (
    .clk       (clk),
    .rst       (rst),
    .clr       (cs_hi),
    .fall      (sclk_fall),
    .start     (pend),
    .result_in (result_in),
    .dout      (dout),
    .st        (sh_st)
  );
endmodule

// File: rtl/sadc_frame_chk.sv
module sadc_frame_chk
  import sadc_pkg::*;
#(
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          cs_hi,
  input logic          sclk_fall,
  input logic          dout,
  input logic          ctrl_strobe,
  input logic [CW-1:0] ctrl_word,
  input sh_state_t     sh_st
);
  // R3
  strobe_single_chk: assert property (@(posedge clk) disable iff (rst)
    ctrl_strobe |=> !ctrl_strobe);

  // R3
  start_is_msb_chk: assert property (@(posedge clk) disable iff (rst)
    ctrl_strobe |-> ctrl_word[CW-1]);

  // R4
  busy_low_chk: assert property (@(posedge clk) disable iff (rst)
    (sh_st == SH_ACQ) |-> !dout);

  // R8
  deselect_low_chk: assert property (@(posedge clk) disable iff (rst)
    cs_hi |=> !dout);

  // R9
  dout_edge_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(dout) |-> $past(sclk_fall || cs_hi));
endmodule

bind sadc_frame sadc_frame_chk #(.CW(CW)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .cs_hi       (cs_hi),
  .sclk_fall   (sclk_fall),
  .dout        (dout),
  .ctrl_strobe (ctrl_strobe),
  .ctrl_word   (ctrl_word),
  .sh_st       (sh_st)
);

// File: tb/sim_sadc_frame.sv
module sim_sadc_frame;
  localparam int CLK_P = 10;
  localparam int HALF  = 8 * CLK_P;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cs_n = 1'b1;
  logic       sclk = 1'b0;
  logic       din = 1'b0;
  logic [7:0] result_in = 8'h00;
  logic       dout;
  logic [7:0] ctrl_word;
  logic       ctrl_strobe;

  int n_chk = 0;
  int n_err = 0;
  bit done_flag = 0;

  logic dq[$];
  logic [7:0] cq[$];

  // bench model of the framing rules
  bit       m_act, m_pend;
  int       m_cnt, m_st, m_idx;
  logic [7:0] m_word, m_res;
  logic     m_dout;

  sadc_frame u0 (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .din(din),
    .result_in(result_in), .dout(dout), .ctrl_word(ctrl_word),
    .ctrl_strobe(ctrl_strobe)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic model_clear();
    m_act = 0; m_pend = 0; m_cnt = 0; m_st = 0; m_idx = 0;
    m_word = 0; m_res = 0; m_dout = 0;
  endtask

  task automatic model_rise(input logic d);
    if (m_act) begin
      m_word = {m_word[6:0], d};
      m_cnt++;
      if (m_cnt == 8) begin
        m_act = 0; m_pend = 1; cq.push_back(m_word);
      end
    end else if (d && !m_pend && m_st != 1) begin
      m_act = 1; m_word = 8'h01; m_cnt = 1;
    end
  endtask

  task automatic model_fall();
    if (m_pend) begin
      m_res = result_in; m_st = 1; m_dout = 0; m_pend = 0;
    end else if (m_st == 1) begin
      m_st = 2; m_idx = 7; m_dout = m_res[7];
    end else if (m_st == 2) begin
      if (m_idx == 0) begin m_st = 0; m_dout = 0; end
      else begin m_idx--; m_dout = m_res[m_idx]; end
    end
  endtask

  // driver: one SCLK period, expected dout pushed for the monitor
  task automatic cyc(input logic d);
    din = d;
    #(HALF);
    dq.push_back(m_dout);
    model_rise(d);
    sclk = 1'b1;
    #(HALF);
    sclk = 1'b0;
    model_fall();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0);
  endtask

  task automatic send_byte(input logic [7:0] c, input logic [7:0] r);
    result_in = r;
    for (int i = 7; i >= 0; i--) cyc(c[i]);
  endtask

  task automatic cs_pulse();
    din = 1'b0;
    cs_n = 1'b1;
    model_clear();
    repeat (40) @(negedge clk);
    check(dout == 1'b0, "R8 dout while deselected", dout, 0);
    cs_n = 1'b0;
    repeat (40) @(negedge clk);
  endtask

  // monitor: dout at each rising SCLK edge
  always @(posedge sclk) begin
    if (dq.size() == 0) check(0, "R5 dout queue empty", dout, 0);
    else begin
      logic e;
      e = dq.pop_front();
      check(dout === e, "R4 R5 R7 dout bit", dout, e);
    end
  end

  // monitor: control byte strobes
  always @(posedge clk) begin
    if (!rst && ctrl_strobe) begin
      if (cq.size() == 0) check(0, "R2 R6 unexpected ctrl_strobe", ctrl_word, 0);
      else begin
        logic [7:0] e;
        e = cq.pop_front();
        check(ctrl_word === e, "R3 ctrl_word", ctrl_word, e);
      end
    end
  end

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 150000);
    check(0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    model_clear();
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(dout == 1'b0, "R1 dout after reset", dout, 0);
    check(ctrl_strobe == 1'b0, "R1 strobe after reset", ctrl_strobe, 0);

    // R2 select falling alone, zeros clocked
    cs_n = 1'b0;
    repeat (40) @(negedge clk);
    idle(5);
    check(cq.size() == 0, "R2 no frame from select edge", cq.size(), 0);

    // R3 R4 R5 16-clock frame
    send_byte(8'hAE, 8'hA5);
    idle(10);

    // R6 high bit in busy slot ignored
    send_byte(8'hC3, 8'h3C);
    cyc(1'b1);
    idle(10);

    // R7 10-clock stream with overlapping control bytes
    send_byte(8'h81, 8'h96);
    idle(2);
    send_byte(8'hB4, 8'h0F);
    idle(2);
    send_byte(8'hFF, 8'hF0);
    idle(2);
    send_byte(8'hD2, 8'h6B);
    idle(12);

    // R7 start on first edge after MSB driven (9-clock frame)
    send_byte(8'h91, 8'h80);
    cyc(1'b0);
    send_byte(8'hF0, 8'h01);
    idle(12);

    // R8 abort a half-captured byte
    cyc(1'b1); cyc(1'b0); cyc(1'b1); cyc(1'b1);
    cs_pulse();
    idle(3);
    // R8 abort mid result
    send_byte(8'h85, 8'h5A);
    idle(4);
    cs_pulse();
    idle(3);
    send_byte(8'hE7, 8'hC9);
    idle(12);

    repeat (20) @(negedge clk);
    check(cq.size() == 0, "R3 all strobes seen", cq.size(), 0);
    check(dq.size() == 0, "R5 all bits sampled", dq.size(), 0);
    finish_run();
  end
endmodule